// File: doc/BRIEF.md
# 64-bit Global Counter with Comparator Timer

This block is a memory-mapped system timer. It contains a 64-bit up-counter that advances once per clock while counting is on, a 64-bit comparator, a 32-bit auto-increment value, one event flag and one level interrupt. Software reaches all of it through a simple word-wide register port with valid, write, byte address and data.

The comparator fires when the counter is at or above the programmed value, not only when the two are equal, so a late-programmed deadline still produces an event. A compare-enable gate keeps the flag quiet while software rewrites the two comparator halves one at a time. Each programmed crossing raises the flag once; after software clears it, it stays clear until the comparator is rewritten or reloaded. In auto-increment mode every event adds the increment to the comparator, which gives periodic ticks with no software in the loop. The counter halves are not captured together, so software reads high, low, high and retries when the two high reads differ.

Top module: `wide_cmp_timer`

## Requirements
- R1: After reset every register (counter, control, status, comparator, increment) reads zero and `irq` is low.
- R2: While control bit 0 is 1 the counter rises by exactly one per clock; while it is 0 the counter holds.
- R3: Writing offset 0x00 loads counter bits 31:0 and writing 0x04 loads bits 63:32; a counter write replaces that cycle's increment, and the low word carries into the high word.
- R4: With control bit 1 set, the flag (status bit 0) is set in the clock after the one in which the 64-bit unsigned counter first is greater than or equal to the comparator; it is never set while the counter is below the comparator.
- R5: Writing 1 to status bit 0 at offset 0x0C clears the flag; writing 0 leaves it unchanged; a new event in the same cycle wins over the clear.
- R6: `irq` is high exactly when the flag, control bit 1 (compare enable) and control bit 2 (interrupt enable) are all 1.
- R7: A single crossing sets the flag at most once: after a clear, the flag stays clear until the comparator is written or reloaded by auto-increment.
- R8: With control bit 3 set, each event adds the increment at 0x18 to the comparator; with bit 3 clear the comparator is left unchanged by an event.
- R9: While control bit 1 is 0 no event occurs even if the counter has passed the comparator; a comparator that is already reached fires the clock after bit 1 is set, and the flag reads 1 one cycle after that.
- R10: The map is 0x00 counter low, 0x04 counter high, 0x08 control (bits 3:0, upper bits read 0), 0x0C status, 0x10 comparator low, 0x14 comparator high, 0x18 increment; 0x1C and misaligned addresses read 0 and ignore writes.
- R11: The high-low-high read sequence, retried when the high reads differ, returns a coherent 64-bit value across a low-word wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the counter advances on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | WORD_W | Write data |
| bus_rdata | output | WORD_W | Read data, valid in the cycle of a read, 0 otherwise |
| irq | output | 1 | Level interrupt |

## Verification
A stuck or skipped counter bit shows at once in two reads a known number of cycles apart, and a broken carry shows in the high word the cycle after the low word wraps. A wrong arming or comparison state shows as a flag that rises one cycle early or late, that rises for a counter still below the comparator, or that comes back after a clear with no new comparator value. A faulty reload shows in the comparator readback once the counter is stopped, since the value then settles to the first multiple step past the counter.

// File: rtl/wct_pkg.sv
package wct_pkg;
  // register word indices (byte offset / 4)
  localparam int REG_CNT_LO = 0;
  localparam int REG_CNT_HI = 1;
  localparam int REG_CTRL   = 2;
  localparam int REG_STAT   = 3;
  localparam int REG_CMP_LO = 4;
  localparam int REG_CMP_HI = 5;
  localparam int REG_INC    = 6;
  localparam int NUM_REGS   = 7;

  localparam int CTRL_W = 4;

  // control bits, bit 0 first from the bottom
  typedef struct packed {
    logic auto_inc;  // bit 3
    logic irq_en;    // bit 2
    logic cmp_en;    // bit 1
    logic run;       // bit 0
  } ctrl_t;
endpackage

// File: rtl/wct_counter.sv
module wct_counter #(
  parameter int WORD_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  run,
  input  logic [1:0]            wr_half,
  input  logic [WORD_W-1:0]     wdata,
  output logic [2*WORD_W-1:0]   value,
  output logic                  tick
);
  localparam int CNT_W = 2 * WORD_W;

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] v);
    return v + CNT_W'(1);
  endfunction

  logic [CNT_W-1:0] cnt_q, cnt_inc, cnt_nxt;

  // a software write to either half takes the place of the increment
  assign tick    = run & ~|wr_half;
  assign cnt_inc = tick ? step(cnt_q) : cnt_q;

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign cnt_nxt[h*WORD_W +: WORD_W] = wr_half[h] ? wdata : cnt_inc[h*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end

  assign value = cnt_q;
endmodule

// File: rtl/wct_comparator.sv
module wct_comparator #(
  parameter int WORD_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cmp_en,
  input  logic                  auto_inc,
  input  logic [1:0]            wr_half,
  input  logic                  wr_inc,
  input  logic [WORD_W-1:0]     wdata,
  input  logic [2*WORD_W-1:0]   count,
  output logic [2*WORD_W-1:0]   cmp_value,
  output logic [WORD_W-1:0]     inc_value,
  output logic                  hit,
  output logic                  reload
);
  localparam int CNT_W = 2 * WORD_W;

  function automatic logic reached(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] t);
    return c >= t;
  endfunction

  function automatic logic [CNT_W-1:0] advance(input logic [CNT_W-1:0] t, input logic [WORD_W-1:0] i);
    return t + CNT_W'(i);
  endfunction

  logic [CNT_W-1:0]  cmp_q, cmp_nxt, cmp_sum;
  logic [WORD_W-1:0] inc_q;
  logic              armed_q;

  // a comparator write in the same cycle re-arms and suppresses the event
  assign hit     = cmp_en & armed_q & ~|wr_half & reached(count, cmp_q);
  assign reload  = hit & auto_inc;
  assign cmp_sum = advance(cmp_q, inc_q);

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign cmp_nxt[h*WORD_W +: WORD_W] =
      wr_half[h] ? wdata : (reload ? cmp_sum[h*WORD_W +: WORD_W] : cmp_q[h*WORD_W +: WORD_W]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q   <= '0;
      inc_q   <= '0;
      armed_q <= 1'b1;
    end else begin
      cmp_q <= cmp_nxt;
      if (wr_inc) inc_q <= wdata;
      if (|wr_half)  armed_q <= 1'b1;
      else if (hit)  armed_q <= auto_inc;
    end
  end

  assign cmp_value = cmp_q;
  assign inc_value = inc_q;
endmodule

// File: rtl/wide_cmp_timer.sv
module wide_cmp_timer #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              irq
);
  import wct_pkg::*;

  localparam int CNT_W   = 2 * WORD_W;
  localparam int IDX_LSB = $clog2(WORD_W / 8);
  localparam int IDX_W   = ADDR_W - IDX_LSB;

  logic [IDX_W-1:0]    idx;
  logic                aligned, wr;
  logic [NUM_REGS-1:0] wr_sel;

  assign idx     = bus_addr[ADDR_W-1:IDX_LSB];
  assign aligned = (bus_addr[IDX_LSB-1:0] == '0);
  assign wr      = bus_valid & bus_write & aligned;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_sel
    assign wr_sel[r] = wr && (idx == IDX_W'(r));
  end

  // control register
  ctrl_t ctrl_q;
  always_ff @(posedge clk) begin
    if (rst)                   ctrl_q <= '0;
    else if (wr_sel[REG_CTRL]) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
  end

  logic cmp_en, irq_en;
  assign cmp_en = ctrl_q.cmp_en;
  assign irq_en = ctrl_q.irq_en;

  // counter and comparator
  logic [CNT_W-1:0]  count, cmp_value;
  logic [WORD_W-1:0] inc_value;
  logic              cnt_tick, cmp_hit, cmp_reload;

  wct_counter #(.WORD_W(WORD_W)) i_counter (
    .clk     (clk),
    .rst     (rst),
    .run     (ctrl_q.run),
    .wr_half ({wr_sel[REG_CNT_HI], wr_sel[REG_CNT_LO]}),
    .wdata   (bus_wdata),
    .value   (count),
    .tick    (cnt_tick)
  );

  wct_comparator #(.WORD_W(WORD_W)) i_comparator (
    .clk       (clk),
    .rst       (rst),
    .cmp_en    (cmp_en),
    .auto_inc  (ctrl_q.auto_inc),
    .wr_half   ({wr_sel[REG_CMP_HI], wr_sel[REG_CMP_LO]}),
    .wr_inc    (wr_sel[REG_INC]),
    .wdata     (bus_wdata),
    .count     (count),
    .cmp_value (cmp_value),
    .inc_value (inc_value),
    .hit       (cmp_hit),
    .reload    (cmp_reload)
  );

  // event flag: set has priority over write-one-to-clear
  logic stat_clr, evt_flag;
  assign stat_clr = wr_sel[REG_STAT] & bus_wdata[0];

  always_ff @(posedge clk) begin
    if (rst)           evt_flag <= 1'b0;
    else if (cmp_hit)  evt_flag <= 1'b1;
    else if (stat_clr) evt_flag <= 1'b0;
  end

  assign irq = evt_flag & cmp_en & irq_en;

  // read path
  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !bus_write && aligned) begin
      case (idx)
        IDX_W'(REG_CNT_LO): bus_rdata = count[WORD_W-1:0];
        IDX_W'(REG_CNT_HI): bus_rdata = count[CNT_W-1:WORD_W];
        IDX_W'(REG_CTRL):   bus_rdata = {{(WORD_W-CTRL_W){1'b0}}, ctrl_q};
        IDX_W'(REG_STAT):   bus_rdata = {{(WORD_W-1){1'b0}}, evt_flag};
        IDX_W'(REG_CMP_LO): bus_rdata = cmp_value[WORD_W-1:0];
        IDX_W'(REG_CMP_HI): bus_rdata = cmp_value[CNT_W-1:WORD_W];
        IDX_W'(REG_INC):    bus_rdata = inc_value;
        default:            bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/wct_timer_chk.sv
module wct_timer_chk #(
  parameter int WORD_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic [2*WORD_W-1:0] count,
  input logic [2*WORD_W-1:0] cmp_value,
  input logic [WORD_W-1:0]   inc_value,
  input logic                cnt_tick,
  input logic                cmp_hit,
  input logic                cmp_reload,
  input logic                evt_flag,
  input logic                stat_clr,
  input logic                cmp_en,
  input logic                irq
);
  localparam int CNT_W = 2 * WORD_W;

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_tick |=> count == $past(count) + CNT_W'(1));

  // R4
  hit_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    cmp_hit |=> evt_flag);

  // R5
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_clr && !cmp_hit) |=> !evt_flag);

  // R6
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
    !evt_flag |-> !irq);

  // R7
  one_shot_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_hit && !cmp_reload) |=> !cmp_hit);

  // R8
  reload_step_chk: assert property (@(posedge clk) disable iff (rst)
    cmp_reload |=> cmp_value == $past(cmp_value) + CNT_W'($past(inc_value)));

  // R9
  flag_gated_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(evt_flag) |-> $past(cmp_en));
endmodule

bind wide_cmp_timer wct_timer_chk #(.WORD_W(WORD_W)) i_wct_chk (
  .clk        (clk),
  .rst        (rst),
  .count      (count),
  .cmp_value  (cmp_value),
  .inc_value  (inc_value),
  .cnt_tick   (cnt_tick),
  .cmp_hit    (cmp_hit),
  .cmp_reload (cmp_reload),
  .evt_flag   (evt_flag),
  .stat_clr   (stat_clr),
  .cmp_en     (cmp_en),
  .irq        (irq)
);

// File: tb/test_wide_cmp_timer.sv
module test_wide_cmp_timer;
  localparam int CLK_PERIOD = 10;

  localparam logic [4:0] A_CLO = 5'h00, A_CHI = 5'h04, A_CTRL = 5'h08, A_STAT = 5'h0C,
                         A_MLO = 5'h10, A_MHI = 5'h14, A_INC = 5'h18, A_NONE = 5'h1C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wide_cmp_timer i_wide_cmp_timer (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    bus_valid = 1'b0;
    bus_write = 1'b0;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic wr32(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd32(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk);
    #1 bus_valid = 1'b0;
  endtask

  task automatic smp_irq(output logic v);
    @(negedge clk);
    #1 v = irq;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  // R1, R10 reset values and unmapped address
  task automatic t_reset();
    logic [31:0] d;
    logic        v;
    do_reset();
    for (int i = 0; i < 8; i++) begin
      rd32(5'(i * 4), d);
      check("R1 reset value", {32'h0, d}, 64'h0);
    end
    smp_irq(v);
    check("R1 irq after reset", {63'h0, v}, 64'h0);
  endtask

  // R10 register readback
  task automatic t_regs();
    logic [31:0] d;
    do_reset();
    wr32(A_CTRL, 32'hFFFF_FFFF);
    rd32(A_CTRL, d);
    check("R10 control reads only bits 3:0", {32'h0, d}, 64'hF);
    wr32(A_CTRL, 32'h0);
    wr32(A_STAT, 32'h1);
    rd32(A_STAT, d);
    check("R10 status cleared", {32'h0, d}, 64'h0);
    wr32(A_MLO, 32'h1234_5678);
    wr32(A_MHI, 32'h9ABC_DEF0);
    wr32(A_INC, 32'h0BAD_F00D);
    wr32(A_NONE, 32'hFFFF_FFFF);
    wr32(5'h11, 32'hFFFF_FFFF);
    rd32(A_MLO, d);
    check("R10 comparator low", {32'h0, d}, 64'h1234_5678);
    rd32(A_MHI, d);
    check("R10 comparator high", {32'h0, d}, 64'h9ABC_DEF0);
    rd32(A_INC, d);
    check("R10 increment", {32'h0, d}, 64'h0BAD_F00D);
    rd32(A_NONE, d);
    check("R10 unmapped reads 0", {32'h0, d}, 64'h0);
  endtask

  // R2, R3 counting, hold, carry and write override
  task automatic t_count();
    logic [31:0] d;
    do_reset();
    wr32(A_CTRL, 32'h1);
    rd32(A_CLO, d);
    check("R2 first cycle after start", {32'h0, d}, 64'd0);
    rd32(A_CLO, d);
    check("R2 one per clock", {32'h0, d}, 64'd1);
    idle(5);
    rd32(A_CLO, d);
    check("R2 after idle", {32'h0, d}, 64'd7);
    wr32(A_CTRL, 32'h0);
    rd32(A_CLO, d);
    check("R2 stop", {32'h0, d}, 64'd9);
    idle(3);
    rd32(A_CLO, d);
    check("R2 hold while stopped", {32'h0, d}, 64'd9);
    wr32(A_CLO, 32'hFFFF_FFFE);
    wr32(A_CHI, 32'h7);
    wr32(A_CTRL, 32'h1);
    rd32(A_CLO, d);
    check("R3 low word loaded", {32'h0, d}, 64'hFFFF_FFFE);
    rd32(A_CHI, d);
    check("R3 high word loaded", {32'h0, d}, 64'h7);
    rd32(A_CLO, d);
    check("R3 low wraps", {32'h0, d}, 64'h0);
    rd32(A_CHI, d);
    check("R3 carry into high", {32'h0, d}, 64'h8);
    wr32(A_CLO, 32'd100);
    rd32(A_CLO, d);
    check("R3 write replaces increment", {32'h0, d}, 64'd100);
  endtask

  // R11 high-low-high read across a wrap
  task automatic t_split();
    logic [31:0] h1, lo, h2;
    int          tries;
    do_reset();
    wr32(A_CLO, 32'hFFFF_FFFE);
    wr32(A_CHI, 32'h2);
    wr32(A_CTRL, 32'h1);
    tries = 0;
    rd32(A_CHI, h2);
    do begin
      h1 = h2;
      rd32(A_CLO, lo);
      rd32(A_CHI, h2);
      if (h1 != h2) tries++;
    end while (h1 != h2 && tries < 4);
    check("R11 coherent value", {h2, lo}, 64'h3_0000_0001);
    check("R11 one retry", 64'(tries), 64'd1);
  endtask

  // R4, R5, R6, R7, R8, R9 compare, flag and interrupt
  task automatic t_compare();
    logic [31:0] d;
    logic        v;
    do_reset();
    wr32(A_CLO, 32'h10);
    wr32(A_CHI, 32'h1);
    wr32(A_MLO, 32'h5);
    wr32(A_MHI, 32'h1);
    idle(3);
    rd32(A_STAT, d);
    check("R9 no event while compare disabled", {32'h0, d}, 64'h0);
    wr32(A_CTRL, 32'h6);
    rd32(A_STAT, d);
    check("R9 flag not yet visible", {32'h0, d}, 64'h0);
    rd32(A_STAT, d);
    check("R4 flag set for counter above comparator", {32'h0, d}, 64'h1);
    smp_irq(v);
    check("R6 irq with both enables", {63'h0, v}, 64'h1);
    rd32(A_MLO, d);
    check("R8 comparator unchanged without auto", {32'h0, d}, 64'h5);
    wr32(A_STAT, 32'h0);
    rd32(A_STAT, d);
    check("R5 writing 0 keeps flag", {32'h0, d}, 64'h1);
    wr32(A_STAT, 32'h1);
    rd32(A_STAT, d);
    check("R5 writing 1 clears flag", {32'h0, d}, 64'h0);
    idle(5);
    rd32(A_STAT, d);
    check("R7 no second event", {32'h0, d}, 64'h0);
    smp_irq(v);
    check("R7 irq stays low", {63'h0, v}, 64'h0);
    wr32(A_MLO, 32'h5);
    rd32(A_STAT, d);
    rd32(A_STAT, d);
    check("R7 comparator write re-arms", {32'h0, d}, 64'h1);
    wr32(A_CTRL, 32'h2);
    smp_irq(v);
    check("R6 irq low without irq enable", {63'h0, v}, 64'h0);
    wr32(A_CTRL, 32'h6);
    smp_irq(v);
    check("R6 irq returns", {63'h0, v}, 64'h1);
    wr32(A_CTRL, 32'h4);
    smp_irq(v);
    check("R6 irq low without compare enable", {63'h0, v}, 64'h0);
    rd32(A_STAT, d);
    check("R6 flag kept when gated", {32'h0, d}, 64'h1);
    // comparator above counter in the high word
    wr32(A_STAT, 32'h1);
    wr32(A_CTRL, 32'h0);
    wr32(A_MLO, 32'h0);
    wr32(A_MHI, 32'h2);
    wr32(A_CTRL, 32'h6);
    idle(3);
    rd32(A_STAT, d);
    check("R4 no event below comparator", {32'h0, d}, 64'h0);
  endtask

  // R4 first event exactly at equality while counting
  task automatic t_cross();
    logic [31:0] d;
    do_reset();
    wr32(A_MLO, 32'h40);
    wr32(A_CTRL, 32'h7);
    rd32(A_STAT, d);
    idle(62);
    rd32(A_STAT, d);
    check("R4 below comparator", {32'h0, d}, 64'h0);
    rd32(A_STAT, d);
    check("R4 equal cycle not yet visible", {32'h0, d}, 64'h0);
    rd32(A_STAT, d);
    check("R4 set after equality", {32'h0, d}, 64'h1);
  endtask

  // R8 periodic auto-increment
  task automatic t_auto();
    logic [31:0] d, v;
    do_reset();
    wr32(A_INC, 32'd10);
    wr32(A_MLO, 32'd10);
    wr32(A_CTRL, 32'hF);
    idle(40);
    wr32(A_CTRL, 32'hE);
    idle(4);
    rd32(A_CLO, v);
    rd32(A_MLO, d);
    check("R8 comparator advanced past counter", {32'h0, d}, 64'(10 * (v / 10 + 1)));
    rd32(A_STAT, d);
    check("R8 flag set", {32'h0, d}, 64'h1);
    wr32(A_STAT, 32'h1);
    rd32(A_STAT, d);
    check("R8 stays clear while stopped", {32'h0, d}, 64'h0);
    wr32(A_CTRL, 32'hF);
    idle(15);
    rd32(A_STAT, d);
    check("R8 periodic event again", {32'h0, d}, 64'h1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    t_reset();
    t_regs();
    t_count();
    t_split();
    t_compare();
    t_cross();
    t_auto();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule